// File: doc/BRIEF.md
# Shared-Buffer IN Endpoint Responder

This block decides how a low-speed USB device answers IN tokens aimed at its two interrupt endpoints, numbers 1 and 2. Both endpoints draw from a single 8-byte transmit buffer. A one-byte control register, written by the CPU, holds four fields:

- a data-sequence bit;
- a buffer-owner select bit;
- a transmit-enable bit;
- a 4-bit byte count.

Per-endpoint enable and stall inputs come from elsewhere in the device.

When the token decoder strobes an IN token, the block issues a one-cycle response request to the packet serializer. The request carries the response kind (none, data, NAK or STALL), the PID, the byte count and the buffer contents. The data-sequence bit changes only when the CPU writes it.

After a data packet the serializer reports the host's acknowledge. The block then raises a transmit-done flag. That flag blocks further data until the CPU clears it.

Top module: `inep_responder`

## Requirements
- R1: The control register is laid out as bit 7 sequence, bit 6 owner, bit 5 transmit enable, bit 4 unused, bits 3:0 count. It reads back with bit 4 always 0, and reset sets all bits to 0.
- R2: A data response carries PID 4'b0011 (DATA0) when the sequence bit is 0 and PID 4'b1011 (DATA1) when it is 1. The sequence bit changes only on a CPU register write, never on a response or an acknowledge.
- R3: An IN token to endpoint 1 or 2 gets a data response (kind 2'd1) under five conditions: the endpoint is enabled, its stall input is 0, transmit enable is 1, the done flag is clear, and the owner bit selects that endpoint (0 for endpoint 1, 1 for endpoint 2).
- R4: If every other data condition holds but the owner bit selects the other endpoint, the response is NAK (kind 2'd2, PID 4'b1010).
- R5: If transmit enable is 0 or the done flag is set, an enabled, non-stalled endpoint 1 or 2 gets NAK.
- R6: An enabled endpoint whose stall input is 1 gets STALL (kind 2'd3, PID 4'b1110). This check wins over every NAK condition.
- R7: An IN token to a disabled endpoint, or to any endpoint number other than 1 or 2, yields kind 2'd0 with PID 0 and length 0.
- R8: A data response's length is the count field clamped to 8, so a count of 0 gives a zero-length packet. Non-data responses carry length 0 and data 0.
- R9: An acknowledge that follows a data response sets the done flag, which then holds until the CPU clears it. An acknowledge that follows any other response leaves the flag unchanged.
- R10: The response request is a one-cycle pulse two cycles after the IN strobe cycle. Its data field holds buffer byte k in bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Control register write strobe |
| cpu_wdata | input | 8 | Control register write data |
| cpu_rdata | output | 8 | Control register read data |
| buf_we | input | 1 | Transmit buffer byte write strobe |
| buf_addr | input | 3 | Transmit buffer byte index |
| buf_wdata | input | 8 | Transmit buffer byte data |
| done_clr | input | 1 | CPU clear of the transmit-done flag |
| tx_done | output | 1 | Transmit-done flag |
| tok_in | input | 1 | IN token strobe from the token decoder |
| tok_ep | input | 4 | Endpoint number of the token |
| ep_en | input | 2 | Endpoint enables, bit 0 for endpoint 1 |
| ep_stall | input | 2 | Endpoint stall bits, bit 0 for endpoint 1 |
| host_ack | input | 1 | Host handshake received after a response |
| rsp_valid | output | 1 | Response request pulse |
| rsp_kind | output | 2 | Response kind: 0 none, 1 data, 2 NAK, 3 STALL |
| rsp_pid | output | 4 | PID of the response packet |
| rsp_len | output | 4 | Data byte count |
| rsp_data | output | 64 | Buffer contents, byte 0 in the low bits |

## Verification
The hardest state to reach is the done flag's effect on later tokens. It needs a full data response, then an acknowledge that is tied to that response, then fresh tokens while the flag stands. The bench runs this sequence with directed steps. It then confirms that acknowledges following NAK responses leave the flag clear. The owner-mismatch and stall-priority cases differ from a data response in only one input each, so the vector table sets them beside their data counterparts.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } rsp_kind_e;

  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_STALL = 4'b1110;

  typedef struct packed {
    logic       seq;
    logic       owner;
    logic       tx_en;
    logic [3:0] count;
  } ctrl_t;
endpackage

// File: rtl/inep_ctrl_reg.sv
module inep_ctrl_reg
  import inep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  wdata,
  output ctrl_t       ctrl,
  output logic [7:0]  rdata
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d.seq   = wdata[7];
      ctrl_d.owner = wdata[6];
      ctrl_d.tx_en = wdata[5];
      ctrl_d.count = wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl  = ctrl_q;
  assign rdata = {ctrl_q.seq, ctrl_q.owner, ctrl_q.tx_en, 1'b0, ctrl_q.count};
endmodule

// File: rtl/inep_tx_buf.sv
module inep_tx_buf #(
  parameter int BYTES  = 8,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [BYTES*DATA_W-1:0] flat
);
  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic              byte_en;
    assign byte_en = we && (addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/inep_decide.sv
module inep_decide
  import inep_pkg::*;
#(
  parameter int EP_W    = 4,
  parameter int CNT_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic [EP_W-1:0]  ep,
  input  logic [1:0]       en,
  input  logic [1:0]       stall,
  input  ctrl_t            ctrl,
  input  logic             done,
  output rsp_kind_e        kind,
  output logic [3:0]       pid,
  output logic [CNT_W-1:0] len
);
  logic hit1, hit2, sel;
  assign hit1 = (ep == EP_W'(1));
  assign hit2 = (ep == EP_W'(2));
  assign sel  = hit2;

  always_comb begin
    kind = RSP_NONE;
    pid  = '0;
    len  = '0;
    if ((hit1 || hit2) && en[sel]) begin
      if (stall[sel]) begin
        kind = RSP_STALL;
        pid  = PID_STALL;
      end else if (!ctrl.tx_en || done || (ctrl.owner != sel)) begin
        kind = RSP_NAK;
        pid  = PID_NAK;
      end else begin
        kind = RSP_DATA;
        pid  = ctrl.seq ? PID_DATA1 : PID_DATA0;
        len  = (ctrl.count > CNT_W'(MAX_LEN)) ? CNT_W'(MAX_LEN) : ctrl.count;
      end
    end
  end
endmodule

// File: rtl/inep_responder.sv
module inep_responder
  import inep_pkg::*;
#(
  parameter int EP_W     = 4,
  parameter int CNT_W    = 4,
  parameter int BUF_B    = 8,
  parameter int BYTE_W   = 8,
  localparam int AW      = $clog2(BUF_B),
  localparam int FLAT_W  = BUF_B * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_addr,
  input  logic [BYTE_W-1:0] buf_wdata,
  input  logic              done_clr,
  output logic              tx_done,
  input  logic              tok_in,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic [1:0]        ep_en,
  input  logic [1:0]        ep_stall,
  input  logic              host_ack,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [3:0]        rsp_pid,
  output logic [CNT_W-1:0]  rsp_len,
  output logic [FLAT_W-1:0] rsp_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  ctrl_t             ctrl;
  logic [FLAT_W-1:0] buf_flat;

  inep_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .we(cpu_we), .wdata(cpu_wdata),
    .ctrl(ctrl), .rdata(cpu_rdata)
  );

  inep_tx_buf #(.BYTES(BUF_B), .DATA_W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .we(buf_we), .addr(buf_addr),
    .wdata(buf_wdata), .flat(buf_flat)
  );

  // stage 1: capture token
  logic            tok_q, tok_d;
  logic [EP_W-1:0] ep_q, ep_d;
  always_comb begin
    tok_d = tok_in;
    ep_d  = tok_in ? tok_ep : ep_q;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tok_q <= 1'b0;
      ep_q  <= '0;
    end else begin
      tok_q <= tok_d;
      ep_q  <= ep_d;
    end
  end

  // decision
  logic       done_q, done_d;
  rsp_kind_e  dec_kind;
  logic [3:0] dec_pid;
  logic [CNT_W-1:0] dec_len;

  inep_decide #(.EP_W(EP_W), .CNT_W(CNT_W), .MAX_LEN(BUF_B)) u_dec (
    .ep(ep_q), .en(ep_en), .stall(ep_stall), .ctrl(ctrl), .done(done_q),
    .kind(dec_kind), .pid(dec_pid), .len(dec_len)
  );

  // stage 2: response request register
  logic              vld_q, vld_d;
  logic [1:0]        kind_q, kind_d;
  logic [3:0]        pid_q, pid_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [FLAT_W-1:0] dat_q, dat_d;
  logic              pend_q, pend_d;

  always_comb begin
    vld_d  = tok_q;
    kind_d = tok_q ? dec_kind : kind_q;
    pid_d  = tok_q ? dec_pid  : pid_q;
    len_d  = tok_q ? dec_len  : len_q;
    dat_d  = dat_q;
    if (tok_q) dat_d = (dec_kind == RSP_DATA) ? buf_flat : '0;
    // pending acknowledge tracks whether the last response was data
    pend_d = pend_q;
    if (tok_q)         pend_d = (dec_kind == RSP_DATA);
    else if (host_ack) pend_d = 1'b0;
    done_d = done_q;
    if (done_clr)                       done_d = 1'b0;
    if (host_ack && pend_q && !tok_q)   done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q  <= 1'b0;
      kind_q <= '0;
      pid_q  <= '0;
      len_q  <= '0;
      dat_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      kind_q <= kind_d;
      pid_q  <= pid_d;
      len_q  <= len_d;
      dat_q  <= dat_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_kind  = kind_q;
  assign rsp_pid   = pid_q;
  assign rsp_len   = len_q;
  assign rsp_data  = dat_q;
  assign tx_done   = done_q;
endmodule

// File: rtl/inep_responder_chk.sv
module inep_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_we,
  input logic [7:0]  cpu_rdata,
  input logic        done_clr,
  input logic        tx_done,
  input logic        tok_in,
  input logic [3:0]  tok_ep,
  input logic        rsp_valid,
  input logic [1:0]  rsp_kind,
  input logic [3:0]  rsp_pid,
  input logic [3:0]  rsp_len
);
  logic [2:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               up_cnt <= '0;
    else if (up_cnt != 3'd7)  up_cnt <= up_cnt + 3'd1;
  end
  logic live;
  assign live = (up_cnt >= 3'd4);

  // R10
  pulse_latency_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    tok_in |-> ##2 rsp_valid);

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (rsp_valid && !tok_in) |=> ##1 !rsp_valid);

  // R2
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !cpu_we |=> $stable(cpu_rdata[7]));

  // R6
  stall_pid_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (rsp_valid && rsp_kind == 2'd3) |-> rsp_pid == 4'b1110);

  // R8
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    rsp_valid |-> rsp_len <= 4'd8);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (tx_done && !done_clr) |=> tx_done);

  // R7
  other_ep_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (tok_in && tok_ep > 4'd2) |-> ##2 (rsp_kind == 2'd0));
endmodule

bind inep_responder inep_responder_chk u_chk (.*);

// File: tb/inep_responder_test.sv
module inep_responder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        buf_we = 1'b0;
  logic [2:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0;
  logic        done_clr = 1'b0;
  logic        tx_done;
  logic        tok_in = 1'b0;
  logic [3:0]  tok_ep = '0;
  logic [1:0]  ep_en = '0;
  logic [1:0]  ep_stall = '0;
  logic        host_ack = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [3:0]  rsp_pid;
  logic [3:0]  rsp_len;
  logic [63:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  inep_responder uut (.*);

  // {ctrl, en, stall, ep, kind, pid, len}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {8'h25, 2'b11, 2'b00, 4'd1, 2'd1, 4'b0011, 4'd5},  // R3 ep1 data0
    {8'hA5, 2'b11, 2'b00, 4'd1, 2'd1, 4'b1011, 4'd5},  // R2 data1
    {8'h65, 2'b11, 2'b00, 4'd2, 2'd1, 4'b0011, 4'd5},  // R3 ep2
    {8'h65, 2'b11, 2'b00, 4'd1, 2'd2, 4'b1010, 4'd0},  // R4 owner ep2, token ep1
    {8'h25, 2'b11, 2'b00, 4'd2, 2'd2, 4'b1010, 4'd0},  // R4 owner ep1, token ep2
    {8'h05, 2'b11, 2'b00, 4'd1, 2'd2, 4'b1010, 4'd0},  // R5 tx disabled
    {8'h25, 2'b11, 2'b01, 4'd1, 2'd3, 4'b1110, 4'd0},  // R6 stall ep1
    {8'h05, 2'b11, 2'b10, 4'd2, 2'd3, 4'b1110, 4'd0},  // R6 stall over NAK
    {8'h25, 2'b10, 2'b00, 4'd1, 2'd0, 4'b0000, 4'd0},  // R7 ep1 disabled
    {8'h25, 2'b11, 2'b00, 4'd3, 2'd0, 4'b0000, 4'd0},  // R7 other ep
    {8'h25, 2'b11, 2'b00, 4'd0, 2'd0, 4'b0000, 4'd0},  // R7 ep0
    {8'h2F, 2'b11, 2'b00, 4'd1, 2'd1, 4'b0011, 4'd8},  // R8 clamp 15
    {8'h29, 2'b11, 2'b00, 4'd1, 2'd1, 4'b0011, 4'd8},  // R8 clamp 9
    {8'h20, 2'b11, 2'b00, 4'd1, 2'd1, 4'b0011, 4'd0}   // R8 zero length
  };

  localparam logic [63:0] BUF_IMG = 64'h8877665544332211;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); cpu_we = 1'b1; cpu_wdata = v;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic send_in(input logic [3:0] ep, input string req,
                         input logic [1:0] k, input logic [3:0] p, input logic [3:0] l);
    @(negedge clk); tok_in = 1'b1; tok_ep = ep;
    @(negedge clk); tok_in = 1'b0;
    chk({req, " early"}, {63'd0, rsp_valid}, 64'd0);
    @(negedge clk);
    chk({req, " valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({req, " kind"}, {62'd0, rsp_kind}, {62'd0, k});
    chk({req, " pid"}, {60'd0, rsp_pid}, {60'd0, p});
    chk({req, " len"}, {60'd0, rsp_len}, {60'd0, l});
    chk({req, " data"}, rsp_data, (k == 2'd1) ? BUF_IMG : 64'd0);
    @(negedge clk);
    chk("R10 pulse width", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic pulse_ack();
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rdata", {56'd0, cpu_rdata}, 64'd0);
    chk("R9 reset done", {63'd0, tx_done}, 64'd0);
    chk("R10 reset valid", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 layout, bit 4 reads 0
    wr_ctrl(8'hFF);
    chk("R1 readback", {56'd0, cpu_rdata}, 64'hEF);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_addr = 3'(i); buf_wdata = BUF_IMG[i*8 +: 8];
    end
    @(negedge clk); buf_we = 1'b0;

    for (int v = 0; v < NV; v++) begin
      wr_ctrl(VEC[v][25:18]);
      ep_en = VEC[v][17:16];
      ep_stall = VEC[v][15:14];
      chk("R1 vector readback", {56'd0, cpu_rdata}, {56'd0, VEC[v][25:18]});
      send_in(VEC[v][13:10], $sformatf("vec%0d", v), VEC[v][9:8], VEC[v][7:4], VEC[v][3:0]);
    end

    // R9 done flag path
    ep_en = 2'b11; ep_stall = 2'b00;
    wr_ctrl(8'hA3);
    send_in(4'd1, "R9 data before ack", 2'd1, 4'b1011, 4'd3);
    pulse_ack();
    @(negedge clk);
    chk("R9 done set", {63'd0, tx_done}, 64'd1);
    // R2 sequence bit not toggled by hardware
    chk("R2 seq unchanged", {56'd0, cpu_rdata}, 64'hA3);
    send_in(4'd1, "R5 NAK while done", 2'd2, 4'b1010, 4'd0);
    repeat (5) @(negedge clk);
    chk("R9 done held", {63'd0, tx_done}, 64'd1);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk("R9 done cleared", {63'd0, tx_done}, 64'd0);
    // acknowledge after NAK must not set done
    wr_ctrl(8'h83);
    send_in(4'd1, "R5 NAK tx off", 2'd2, 4'b1010, 4'd0);
    pulse_ack();
    @(negedge clk);
    chk("R9 ack after NAK", {63'd0, tx_done}, 64'd0);
    // R6 stall wins even while done is set
    wr_ctrl(8'h23);
    send_in(4'd1, "R9 second data", 2'd1, 4'b0011, 4'd3);
    pulse_ack();
    ep_stall = 2'b01;
    send_in(4'd1, "R6 stall over done", 2'd3, 4'b1110, 4'd0);
    ep_stall = 2'b00;

    finish_run();
  end
endmodule